// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Mapper

This block sits between a console CPU, its picture processor and a cartridge's program and pattern memories. It watches CPU writes in the upper half of the address map. One decoded address loads a select byte. The select byte gives two layout controls and a 3-bit pointer to one of eight bank registers. A second decoded address loads bank data into the register that the pointer names. From these registers the block turns every CPU address in the four 8 KB program windows into a physical program address. It also turns every PPU address in the eight 1 KB pattern slots into a physical pattern address.

Bank data written while the whole select byte is 5 or less does two extra things. Bit 5 of the data sets the one-screen nametable mirroring, and only the low five bits of the data are stored. Both address outputs are combinational from the current register state. A register write takes effect at the clock edge on which the write strobe is sampled. Every bank number is reduced modulo the bank count by masking, so the program bank count and the pattern page count must be powers of two. All interfaces are plain strobes and addresses, with no handshake and no back-pressure.

Top module: `bank_mapper`

## Requirements
- R1: A write with `cpu_we` high whose address ANDed with 0xE001 equals 0x8000 loads `cpu_data` into the select byte. When the masked address equals 0x8001, the write stores bank data. Either update is visible on the outputs right after the rising edge that samples the strobe. Aliases in address bits 12:1 decode the same way.
- R2: No register changes, and neither output nor `mirror_b` changes, in either of two cases: a write whose masked address is anything else (for example 0xA000, 0xC001, 0xE000 or 0x6000), or any cycle with `cpu_we` low.
- R3: A bank data write updates the bank register numbered by select bits 2:0.
- R4: If the select byte is 0x05 or less at a data write, `mirror_b` becomes 0 (first nametable) when data bit 5 is 1, and 1 (second nametable) when it is 0. Only data bits 4:0 are stored. If the select byte is above 0x05, the full byte is stored and `mirror_b` keeps its value.
- R5: Registers 0 and 1 store the value with bit 0 cleared. Each covers two consecutive 1 KB pages, the stored value and the stored value plus 1. Registers 2 to 5 each cover one 1 KB page.
- R6: With select bit 6 clear, the program windows at 0x8000, 0xA000, 0xC000 and 0xE000 use register 6, register 7, bank N-2 and bank N-1. With bit 6 set, they use bank N-2, register 7, register 6 and bank N-1. N is `PRG_BANKS`, and `prg_addr` = bank*8192 + `cpu_addr`[12:0].
- R7: A program bank number is taken modulo `PRG_BANKS`. A pattern page number is taken modulo `CHR_PAGES`.
- R8: With select bit 7 clear, pattern slots 0 to 3 (`ppu_addr`[12:10]) come from registers 0 and 1 as two pairs of pages, and slots 4 to 7 come from registers 2 to 5. With bit 7 set, the two groups of four slots trade places. `chr_addr` = page*1024 + `ppu_addr`[9:0].
- R9: After reset the select byte is 0, `mirror_b` is 0, and registers 0 to 7 hold 0, 2, 4, 5, 6, 7, 0 and 1.
- R10: `prg_hit` equals `cpu_addr`[15]. `chr_hit` is high exactly when `ppu_addr`[13] is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one sample per cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | Picture processor address |
| prg_hit | output | 1 | CPU address lies in a program window |
| prg_addr | output | log2(PRG_BANKS)+13 | Physical program address |
| chr_hit | output | 1 | PPU address lies in pattern space |
| chr_addr | output | log2(CHR_PAGES)+10 | Physical pattern address |
| mirror_b | output | 1 | One-screen mirroring: 0 first nametable, 1 second |

## Verification
A wrong bank register appears at once as a wrong page in the one window or slot that uses it. The error shows in the very cycle after the bad write, and only while the right swap bit is set, so the bench reads every window and slot after each write. A select byte stored wrongly misplaces whole groups of windows. A wrong narrow-range test can do two things: it can corrupt the upper data bits, which shows only when a later window read lands on that register, or it can flip `mirror_b` on a write where the value should hold. Each select value is swept with a distinct data byte, so these faults appear within one write-and-read round.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  localparam int BANK_REGS = 8;
  localparam int DATA_W    = 8;

  typedef logic [DATA_W-1:0] bank_val_t;

  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_SELECT = 2'd1,
    WR_DATA   = 2'd2
  } wr_kind_t;

  // power-on contents: two pattern pairs, four single pages, two program banks
  function automatic bank_val_t bank_reset_value(input int idx);
    if (idx < 2)      return bank_val_t'(idx * 2);
    else if (idx < 6) return bank_val_t'(idx + 2);
    else              return bank_val_t'(idx - 6);
  endfunction

endpackage

// File: rtl/bank_mapper_decode.sv
module bank_mapper_decode #(
  parameter logic [15:0] ADDR_MASK  = 16'hE001,
  parameter logic [15:0] SEL_MATCH  = 16'h8000,
  parameter logic [15:0] DATA_MATCH = 16'h8001
) (
  input  logic                        cpu_we,
  input  logic [15:0]                 cpu_addr,
  output bank_mapper_pkg::wr_kind_t   wr_kind
);
  import bank_mapper_pkg::*;

  logic [15:0] masked;
  assign masked = cpu_addr & ADDR_MASK;

  always_comb begin
    wr_kind = WR_NONE;
    if (cpu_we) begin
      if (masked == SEL_MATCH)       wr_kind = WR_SELECT;
      else if (masked == DATA_MATCH) wr_kind = WR_DATA;
    end
  end
endmodule

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  bank_mapper_pkg::wr_kind_t              wr_kind,
  input  logic [7:0]                             cpu_data,
  output logic [7:0]                             sel_q,
  output logic                                   mirror_q,
  output bank_mapper_pkg::bank_val_t [7:0]       banks_o
);
  import bank_mapper_pkg::*;

  localparam logic [7:0] NARROW_LIMIT = 8'd5;

  logic      narrow;
  logic [2:0] target;
  bank_val_t store_val;
  bank_val_t bank_r [BANK_REGS];

  assign narrow = (sel_q <= NARROW_LIMIT);
  assign target = sel_q[2:0];

  always_comb begin
    store_val = cpu_data;
    if (narrow) store_val = {3'b000, cpu_data[4:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= 8'h00;
      mirror_q <= 1'b0;
    end else begin
      if (wr_kind == WR_SELECT) sel_q <= cpu_data;
      if (wr_kind == WR_DATA && narrow) mirror_q <= ~cpu_data[5];
    end
  end

  for (genvar i = 0; i < BANK_REGS; i++) begin : g_bank
    logic hit;
    assign hit = (wr_kind == WR_DATA) && (target == 3'(i));
    if (i < 2) begin : g_pair
      always_ff @(posedge clk) begin
        if (!rst_n)   bank_r[i] <= bank_reset_value(i);
        else if (hit) bank_r[i] <= {store_val[7:1], 1'b0};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)   bank_r[i] <= bank_reset_value(i);
        else if (hit) bank_r[i] <= store_val;
      end
    end
    assign banks_o[i] = bank_r[i];
  end

  p_select_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_kind == WR_SELECT |=> sel_q == $past(cpu_data));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_kind == WR_NONE |=> $stable(sel_q) && $stable(mirror_q) && $stable(banks_o));

  p_mirror_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == WR_DATA && sel_q > 8'd5) |=> $stable(mirror_q));

  p_mirror_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == WR_DATA && sel_q <= 8'd5) |=> mirror_q == !$past(cpu_data[5]));
endmodule

// File: rtl/bank_mapper_prg.sv
module bank_mapper_prg #(
  parameter int PRG_BANKS = 32,
  localparam int BW = $clog2(PRG_BANKS),
  localparam int AW = BW + 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [15:0]                  cpu_addr,
  input  logic                         layout_swap,
  input  bank_mapper_pkg::bank_val_t   bank_a,
  input  bank_mapper_pkg::bank_val_t   bank_b,
  output logic                         prg_hit,
  output logic [AW-1:0]                prg_addr
);
  localparam logic [BW-1:0] LAST_BANK   = BW'(PRG_BANKS - 1);
  localparam logic [BW-1:0] SECOND_LAST = BW'(PRG_BANKS - 2);

  logic [1:0]    window;
  logic [BW-1:0] a_m, b_m, bank;

  assign window = cpu_addr[14:13];
  assign a_m    = BW'(bank_a);
  assign b_m    = BW'(bank_b);

  always_comb begin
    unique case (window)
      2'd0:    bank = layout_swap ? SECOND_LAST : a_m;
      2'd1:    bank = b_m;
      2'd2:    bank = layout_swap ? a_m : SECOND_LAST;
      default: bank = LAST_BANK;
    endcase
  end

  assign prg_hit  = cpu_addr[15];
  assign prg_addr = {bank, cpu_addr[12:0]};

  p_last_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (prg_addr[AW-1:13] == LAST_BANK && prg_hit));
endmodule

// File: rtl/bank_mapper_chr.sv
module bank_mapper_chr #(
  parameter int CHR_PAGES = 128,
  localparam int PW = $clog2(CHR_PAGES),
  localparam int AW = PW + 10
) (
  input  logic [13:0]                          ppu_addr,
  input  logic                                 half_swap,
  input  bank_mapper_pkg::bank_val_t [5:0]     chr_banks,
  output logic                                 chr_hit,
  output logic [AW-1:0]                        chr_addr
);
  logic [2:0]    eff_slot;
  logic [PW-1:0] page_c [8];

  assign eff_slot = ppu_addr[12:10] ^ {half_swap, 2'b00};

  for (genvar k = 0; k < 8; k++) begin : g_slot
    if (k < 4) begin : g_pair
      assign page_c[k] = PW'(chr_banks[k / 2] | 8'(k % 2));
    end else begin : g_single
      assign page_c[k] = PW'(chr_banks[k - 2]);
    end
  end

  assign chr_hit  = ~ppu_addr[13];
  assign chr_addr = {page_c[eff_slot], ppu_addr[9:0]};
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int PRG_BANKS = 32,
  parameter int CHR_PAGES = 128,
  localparam int PRG_AW = $clog2(PRG_BANKS) + 13,
  localparam int CHR_AW = $clog2(CHR_PAGES) + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic [13:0]       ppu_addr,
  output logic              prg_hit,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              chr_hit,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              mirror_b
);
  import bank_mapper_pkg::*;

  wr_kind_t        wr_kind;
  logic [7:0]      sel_q;
  bank_val_t [7:0] banks;

  bank_mapper_decode u_decode (
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .wr_kind  (wr_kind)
  );

  bank_mapper_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_kind  (wr_kind),
    .cpu_data (cpu_data),
    .sel_q    (sel_q),
    .mirror_q (mirror_b),
    .banks_o  (banks)
  );

  bank_mapper_prg #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .layout_swap (sel_q[6]),
    .bank_a      (banks[6]),
    .bank_b      (banks[7]),
    .prg_hit     (prg_hit),
    .prg_addr    (prg_addr)
  );

  bank_mapper_chr #(.CHR_PAGES(CHR_PAGES)) u_chr (
    .ppu_addr  (ppu_addr),
    .half_swap (sel_q[7]),
    .chr_banks (banks[5:0]),
    .chr_hit   (chr_hit),
    .chr_addr  (chr_addr)
  );
endmodule

// File: tb/bank_mapper_test.sv
`timescale 1ns/1ps
module bank_mapper_test;
  localparam int NP = 8;
  localparam int NC = 32;
  localparam int PAW = $clog2(NP) + 13;
  localparam int CAW = $clog2(NC) + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic [13:0] ppu_addr = 14'h0000;
  logic prg_hit, chr_hit, mirror_b;
  logic [PAW-1:0] prg_addr;
  logic [CAW-1:0] chr_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model, written from the requirements
  int m_sel;
  int m_mir;
  int m_r[8];

  always #4 clk = ~clk;

  bank_mapper #(.PRG_BANKS(NP), .CHR_PAGES(NC)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_hit(prg_hit),
    .prg_addr(prg_addr), .chr_hit(chr_hit), .chr_addr(chr_addr),
    .mirror_b(mirror_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sel = 0; m_mir = 0;
    m_r[0] = 0; m_r[1] = 2; m_r[2] = 4; m_r[3] = 5;
    m_r[4] = 6; m_r[5] = 7; m_r[6] = 0; m_r[7] = 1;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    int v;
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    if ((a & 16'hE001) == 16'h8000) m_sel = d;
    else if ((a & 16'hE001) == 16'h8001) begin
      v = d;
      if (m_sel <= 5) begin
        m_mir = d[5] ? 0 : 1;
        v = d & 8'h1F;
      end
      if ((m_sel % 8) < 2) v = v & 8'hFE;
      m_r[m_sel % 8] = v;
    end
  endtask

  task automatic check_all(input string tag);
    int b, pg, ofs, grp, w4;
    for (int w = 0; w < 4; w++) begin
      ofs = (w * 1237 + 5) & 8191;
      cpu_addr = 16'h8000 | 16'(w << 13) | 16'(ofs);
      #1;
      if (w == 3) b = NP - 1;
      else if (w == 1) b = m_r[7];
      else if ((w == 0) != m_sel[6]) b = m_r[6];
      else b = NP - 2;
      check({tag, " R6 R7 prg window"}, int'(prg_addr), (b % NP) * 8192 + ofs);
    end
    for (int s = 0; s < 8; s++) begin
      ofs = (s * 97 + 3) & 1023;
      ppu_addr = 14'(s << 10) | 14'(ofs);
      #1;
      grp = (s / 4) ^ int'(m_sel[7]);
      w4  = s % 4;
      if (grp == 0) pg = m_r[w4 / 2] + (w4 % 2);
      else          pg = m_r[2 + w4];
      check({tag, " R5 R7 R8 pattern slot"}, int'(chr_addr), (pg % NC) * 1024 + ofs);
    end
    check({tag, " R4 mirror"}, int'(mirror_b), m_mir);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: power-on state
    check_all("R9 reset");

    // R10: window hit flags
    cpu_addr = 16'h7FFF; #1; check("R10 prg_hit low", int'(prg_hit), 0);
    cpu_addr = 16'h8000; #1; check("R10 prg_hit high", int'(prg_hit), 1);
    ppu_addr = 14'h2000; #1; check("R10 chr_hit low", int'(chr_hit), 0);
    ppu_addr = 14'h1FFF; #1; check("R10 chr_hit high", int'(chr_hit), 1);

    // R1 R3 R4 R5: every select byte, distinct data, aliased addresses
    for (int s = 0; s < 256; s++) begin
      cpu_write(16'h8000 | 16'((s * 4) & 16'h1FFE), 8'(s));
      cpu_write(16'h8001 | 16'((s * 6) & 16'h1FFE), 8'((s * 37 + 11) & 255));
      check_all("R1 R3 sweep");
    end

    // R4: narrow range with bit 5 set and clear, then a wide select
    cpu_write(16'h8000, 8'h02);
    cpu_write(16'h8001, 8'hE5);
    check_all("R4 narrow set");
    cpu_write(16'h8001, 8'hDF);
    check_all("R4 narrow clear");
    cpu_write(16'h8000, 8'h46);
    cpu_write(16'h8001, 8'h25);
    check_all("R4 wide keeps mirror");

    // R2: undecoded addresses and an idle strobe change nothing
    cpu_write(16'h8000, 8'h03);
    cpu_write(16'h8001, 8'h00);
    check_all("R2 setup");
    cpu_write(16'hA000, 8'hFF); check_all("R2 A000");
    cpu_write(16'hA001, 8'hFF); check_all("R2 A001");
    cpu_write(16'hC000, 8'hFF); check_all("R2 C000");
    cpu_write(16'hC001, 8'hFF); check_all("R2 C001");
    cpu_write(16'hE000, 8'hFF); check_all("R2 E000");
    cpu_write(16'hE001, 8'hFF); check_all("R2 E001");
    cpu_write(16'h6000, 8'hFF); check_all("R2 6000");
    cpu_write(16'h0001, 8'hFF); check_all("R2 0001");
    @(negedge clk);
    cpu_addr = 16'h8001; cpu_data = 8'hFF; cpu_we = 1'b0;
    @(negedge clk);
    check_all("R2 strobe low");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule